// File: doc/BRIEF.md
# Sequential Three-Step Combination Lock Controller

This block is the control half of a keypad-style lock. The user's entry is compared against one stored code at a time by a comparator outside the block. The controller tells that comparator which stored code to use through a select output. It then acts on the comparator's match flag each time a "new entry" strobe arrives. The strobe marks the cycle in which a fresh entry is valid.

A full run of matching entries, one per stored code and in order, unlocks the lock. Any strobed entry that does not match sends the controller into a fault state. The fault state is sticky: only the synchronous reset leaves it. The unlocked state is held in the same way until reset. Cycles without a strobe change nothing, so entries may be spaced by any number of idle cycles.

The number of codes in the sequence is a parameter and defaults to three. The state is kept in registers, and both outputs are decoded from those registers alone. Because of this, the outputs move only at clock edges and never follow the inputs within a cycle.

Top module: `lock_seq_ctrl`

## Requirements
- R1: With `rst` high at a rising clock edge, the controller returns to the first code step from any state. After that edge, `code_sel` is 0 and `unlocked` is 0.
- R2: While waiting for entry k (k counted from 0 up to NUM_CODES-1), `code_sel` equals k as an unsigned binary number and `unlocked` is 0.
- R3: At a rising edge with `entry_stb` high and `match_in` high while waiting for entry k, the controller moves to step k+1. When k is the last step, it moves to the unlocked state instead.
- R4: At a rising edge with `entry_stb` high and `match_in` low while waiting for any entry, the controller enters the fault state. In the fault state `code_sel` is 0 and `unlocked` is 0.
- R5: At a rising edge with `entry_stb` low, the state does not change, whatever the value of `match_in`.
- R6: The unlocked state keeps `unlocked` at 1 and `code_sel` at 0 until reset, whatever the strobes and match values. No other state drives `unlocked` to 1.
- R7: The fault state is held until reset. A later strobed sequence of correct entries does not advance `code_sel` and does not unlock.
- R8: Both outputs depend only on registered state. A change of `entry_stb` or `match_in` between clock edges leaves both outputs unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| entry_stb | input | 1 | Marks the cycle in which a new entry is presented |
| match_in | input | 1 | Comparator result: the entry equals the selected code |
| code_sel | output | SEL_W | Index of the stored code the comparator must use (0 = first) |
| unlocked | output | 1 | High only in the unlocked state |

## Verification
The bench builds the controller with its default of three codes. It models the comparator with three 4-bit stored values and the code select. With this configuration, every ordered triple of 4-bit entries can be tried: all 4096 of them. That sweep reaches a mismatch at each of the three steps, for every wrong value. A fourth strobed entry after each sequence exercises the holding behaviour of both the unlocked and the fault states. Idle gaps between entries, and input changes between clock edges, cover the hold and registered-output rules.

// File: rtl/lock_pkg.sv
package lock_pkg;

    // Overall condition of the controller.
    typedef enum logic [1:0] {
        PH_ENTRY    = 2'b00,
        PH_UNLOCKED = 2'b01,
        PH_FAULT    = 2'b10
    } lock_phase_e;

    // Width needed to index NCODES stored codes (at least one bit).
    function automatic int sel_width(input int ncodes);
        return (ncodes > 1) ? $clog2(ncodes) : 1;
    endfunction

    // The phase that follows a strobed entry, given the comparator result.
    function automatic lock_phase_e phase_after_entry(input logic hit,
                                                      input logic last_step);
        if (!hit)
            return PH_FAULT;
        else if (last_step)
            return PH_UNLOCKED;
        else
            return PH_ENTRY;
    endfunction

endpackage

// File: rtl/lock_step_logic.sv
module lock_step_logic
    import lock_pkg::*;
#(
    parameter int NUM_CODES = 3,
    parameter int IDX_W     = sel_width(NUM_CODES)
) (
    input  lock_phase_e      cur_phase,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic             entry_stb,
    input  logic             match_in,
    output lock_phase_e      nxt_phase,
    output logic [IDX_W-1:0] nxt_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CODES - 1);

    logic        at_last;
    lock_phase_e strobed_phase;

    assign at_last       = (cur_idx == LAST_IDX);
    assign strobed_phase = phase_after_entry(match_in, at_last);

    always_comb begin
        nxt_phase = cur_phase;
        nxt_idx   = cur_idx;
        case (cur_phase)
            PH_ENTRY: begin
                if (entry_stb) begin
                    nxt_phase = strobed_phase;
                    if (strobed_phase == PH_ENTRY)
                        nxt_idx = cur_idx + 1'b1;
                    else
                        nxt_idx = '0;
                end
            end
            PH_UNLOCKED: begin
                nxt_phase = PH_UNLOCKED;
                nxt_idx   = '0;
            end
            PH_FAULT: begin
                nxt_phase = PH_FAULT;
                nxt_idx   = '0;
            end
            default: begin
                nxt_phase = PH_FAULT;
                nxt_idx   = '0;
            end
        endcase
    end

endmodule

// File: rtl/lock_state_reg.sv
module lock_state_reg
    import lock_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  lock_phase_e      nxt_phase,
    input  logic [IDX_W-1:0] nxt_idx,
    output lock_phase_e      phase_q,
    output logic [IDX_W-1:0] idx_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ENTRY;
            idx_q   <= '0;
        end else begin
            phase_q <= nxt_phase;
            idx_q   <= nxt_idx;
        end
    end

endmodule

// File: rtl/lock_out_decode.sv
module lock_out_decode
    import lock_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  lock_phase_e      phase_q,
    input  logic [IDX_W-1:0] idx_q,
    output logic [IDX_W-1:0] code_sel,
    output logic             unlocked
);

    assign code_sel = (phase_q == PH_ENTRY) ? idx_q : '0;
    assign unlocked = (phase_q == PH_UNLOCKED);

endmodule

// File: rtl/lock_seq_ctrl.sv
module lock_seq_ctrl
    import lock_pkg::*;
#(
    parameter int NUM_CODES = 3,
    localparam int SEL_W    = sel_width(NUM_CODES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             entry_stb,
    input  logic             match_in,
    output logic [SEL_W-1:0] code_sel,
    output logic             unlocked
);

    lock_phase_e      phase_q;
    lock_phase_e      nxt_phase;
    logic [SEL_W-1:0] idx_q;
    logic [SEL_W-1:0] nxt_idx;

    lock_step_logic #(
        .NUM_CODES (NUM_CODES),
        .IDX_W     (SEL_W)
    ) u_step (
        .cur_phase (phase_q),
        .cur_idx   (idx_q),
        .entry_stb (entry_stb),
        .match_in  (match_in),
        .nxt_phase (nxt_phase),
        .nxt_idx   (nxt_idx)
    );

    lock_state_reg #(
        .IDX_W (SEL_W)
    ) u_reg (
        .clk       (clk),
        .rst       (rst),
        .nxt_phase (nxt_phase),
        .nxt_idx   (nxt_idx),
        .phase_q   (phase_q),
        .idx_q     (idx_q)
    );

    lock_out_decode #(
        .IDX_W (SEL_W)
    ) u_dec (
        .phase_q  (phase_q),
        .idx_q    (idx_q),
        .code_sel (code_sel),
        .unlocked (unlocked)
    );

endmodule

// File: rtl/lock_seq_ctrl_chk.sv
module lock_seq_ctrl_chk
    import lock_pkg::*;
#(
    parameter int NUM_CODES = 3,
    localparam int SEL_W    = sel_width(NUM_CODES)
) (
    input logic             clk,
    input logic             rst,
    input logic             entry_stb,
    input logic             match_in,
    input logic [SEL_W-1:0] code_sel,
    input logic             unlocked,
    input lock_phase_e      phase_q
);

    // R1
    reset_home_chk: assert property (@(posedge clk)
        rst |=> (code_sel == '0 && !unlocked && phase_q == PH_ENTRY));

    // R3
    advance_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ENTRY && entry_stb && match_in && int'(code_sel) < NUM_CODES - 1)
        |=> (phase_q == PH_ENTRY && code_sel == $past(code_sel) + 1'b1));

    // R3
    final_open_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ENTRY && entry_stb && match_in && int'(code_sel) == NUM_CODES - 1)
        |=> unlocked);

    // R4
    mismatch_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ENTRY && entry_stb && !match_in)
        |=> (phase_q == PH_FAULT && code_sel == '0 && !unlocked));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !entry_stb |=> ($stable(code_sel) && $stable(unlocked) && $stable(phase_q)));

    // R6
    open_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        unlocked |=> unlocked);

    // R6
    open_only_chk: assert property (@(posedge clk) disable iff (rst)
        unlocked |-> (phase_q == PH_UNLOCKED && code_sel == '0));

    // R7
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FAULT) |=> (phase_q == PH_FAULT && !unlocked && code_sel == '0));

endmodule

bind lock_seq_ctrl lock_seq_ctrl_chk #(
    .NUM_CODES (NUM_CODES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .entry_stb (entry_stb),
    .match_in  (match_in),
    .code_sel  (code_sel),
    .unlocked  (unlocked),
    .phase_q   (phase_q)
);

// File: tb/lock_seq_ctrl_bench.sv
module lock_seq_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCODES     = 3;
    localparam int SW         = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          entry_stb = 1'b0;
    logic [3:0]    entry_val = 4'd0;
    logic          match_in;
    logic [SW-1:0] code_sel;
    logic          unlocked;

    int checks   = 0;
    int failures = 0;

    // Expected state: 0 = waiting for an entry, 1 = unlocked, 2 = fault.
    int exp_ph  = 0;
    int exp_idx = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [3:0] stored_code(input int k);
        case (k)
            0:       return 4'd5;
            1:       return 4'd9;
            2:       return 4'd3;
            default: return 4'd15;
        endcase
    endfunction

    // Comparator model: compares the entry with the code picked by code_sel.
    assign match_in = (entry_val == stored_code(int'(code_sel)));

    lock_seq_ctrl #(.NUM_CODES(NCODES)) u_lock_seq_ctrl (
        .clk       (clk),
        .rst       (rst),
        .entry_stb (entry_stb),
        .match_in  (match_in),
        .code_sel  (code_sel),
        .unlocked  (unlocked)
    );

    task automatic check_out(input string tag);
        int  want_sel;
        logic want_unl;
        want_sel = (exp_ph == 0) ? exp_idx : 0;
        want_unl = (exp_ph == 1);
        checks++;
        if (int'(code_sel) != want_sel || unlocked != want_unl) begin
            failures++;
            $display("FAIL %s: code_sel=%0d unlocked=%0b expected code_sel=%0d unlocked=%0b",
                     tag, code_sel, unlocked, want_sel, want_unl);
        end
    endtask

    function automatic string tag_for_state();
        if (exp_ph == 1) return "R6";
        if (exp_ph == 2) return "R7";
        return "R2/R3";
    endfunction

    // One clock cycle with the given inputs. The bench model is updated from the requirements.
    task automatic step(input logic stb, input logic [3:0] val);
        @(negedge clk);
        entry_stb = stb;
        entry_val = val;
        #1;
        check_out("R8");           // outputs unaffected until the next edge
        @(posedge clk);
        if (stb && exp_ph == 0) begin
            if (val == stored_code(exp_idx)) begin
                if (exp_idx == NCODES - 1) begin
                    exp_ph  = 1;
                    exp_idx = 0;
                end else begin
                    exp_idx = exp_idx + 1;
                end
            end else begin
                exp_ph  = 2;
                exp_idx = 0;
            end
        end
        #1;
        if (!stb) check_out("R5");
        else if (exp_ph == 2) check_out("R4");
        else check_out(tag_for_state());
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst       = 1'b1;
        entry_stb = 1'b0;
        @(posedge clk);
        exp_ph  = 0;
        exp_idx = 0;
        #1;
        check_out("R1");
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        check_out("R2");

        // Long idle gaps with a wrong value present: no movement (R5).
        for (int i = 0; i < 4; i++) step(1'b0, 4'd0);
        step(1'b1, stored_code(0));
        for (int i = 0; i < 3; i++) step(1'b0, 4'd7);
        step(1'b1, stored_code(1));
        step(1'b0, 4'd1);
        step(1'b1, stored_code(2));
        // Unlocked; strobes of any value keep it there (R6).
        step(1'b1, 4'd0);
        step(1'b1, stored_code(0));
        step(1'b0, 4'd2);
        // Reset from the unlocked state (R1).
        do_reset();

        // Mismatch at each step, then correct entries are ignored (R4, R7).
        for (int pos = 0; pos < NCODES; pos++) begin
            for (int k = 0; k < pos; k++) step(1'b1, stored_code(k));
            step(1'b1, stored_code(pos) ^ 4'd1);
            for (int k = 0; k < NCODES; k++) step(1'b1, stored_code(k));
            do_reset();        // reset from the fault state (R1)
        end

        // Sweep of every ordered triple of entries, with a gap after the first.
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int c = 0; c < 16; c++) begin
                    step(1'b1, 4'(a));
                    step(1'b0, 4'(c));
                    step(1'b1, 4'(b));
                    step(1'b1, 4'(c));
                    step(1'b1, stored_code(0));
                    do_reset();
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule